// File: doc/BRIEF.md
# Serial Port Interrupt Status Unit

This block gathers the conditions a synchronous serial port can raise and folds them into a single processor interrupt line. Some sources are live levels taken from FIFO occupancy: receive at or above half depth, transmit at or below half depth, and transmit fully drained. The others are events that stay latched until software clears them: receive overrun, receive timeout, and receive or transmit DMA completion.

Software reaches the unit over a small register bus. The bus exposes four locations: a raw status view, a mask, a masked view, and a write-one-to-clear strobe. The FIFOs, the serial shifter and the DMA engine stay outside the block. They appear here only as occupancy counts, per-word strobes, a bit-period tick and completion pulses.

The register bus is plain and never stalls: a write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` whenever `bus_sel` is high with `bus_wr` low. It reads as zero at all other times.

Top module: `serial_irq_unit`

## Requirements
- R1: After reset the mask and all latched event bits are 0, and `irq` is 0. The status bit map is: bit0 overrun, bit1 timeout, bit2 RX-at-least-half, bit3 TX-at-most-half, bit4 RX DMA done, bit5 TX DMA done, bit6 TX drained. Bus addresses are 0 raw, 1 mask, 2 masked, 3 clear.
- R2: Raw bit2 equals (`rx_level` >= DEPTH/2) in the same cycle.
- R3: Raw bit3 equals (`tx_level` <= DEPTH/2). Raw bit6 equals (`tx_level` == 0 and `tx_shift_busy` low). Neither bit can be latched or cleared.
- R4: A `rx_word_arrive` pulse while `rx_level` == DEPTH sets raw bit0 from the next cycle on.
- R5: Raw bit1 sets at the TIMEOUT_BITS-th `bit_tick` counted while the RX FIFO is non-empty with no arrival and no read. Any arrival or read, and an empty FIFO, restart the count.
- R6: A one-cycle `dma_rx_done` sets raw bit4, and a one-cycle `dma_tx_done` sets raw bit5. Both bits stay set until cleared.
- R7: Writing address 3 clears each of bits 0, 1, 4 and 5 whose write-data bit is 1. Zero bits, and ones in bits 2, 3 and 6, have no effect.
- R8: When a set event and a clear write hit the same bit in the same cycle, the bit ends set.
- R9: The mask at address 1 reads back what was written. The masked view at address 2 equals raw AND mask.
- R10: `irq` is a register that holds the OR of the masked status of the previous cycle.
- R11: Reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 7 | Write data |
| bus_rdata | output | 7 | Read data |
| rx_level | input | LVL_W | RX FIFO occupancy |
| tx_level | input | LVL_W | TX FIFO occupancy |
| tx_shift_busy | input | 1 | Last TX word still shifting out |
| rx_word_arrive | input | 1 | Received word presented to the RX FIFO |
| rx_word_read | input | 1 | RX FIFO popped by software or DMA |
| bit_tick | input | 1 | One pulse per serial bit period |
| dma_rx_done | input | 1 | RX DMA completion pulse |
| dma_tx_done | input | 1 | TX DMA completion pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions check on every cycle that the read-back of the RX threshold bit follows `rx_level`, that the masked view never exposes an unmasked bit, and that `irq` tracks the previous cycle's masked status. They also check that overrun and DMA events latch on the next cycle, that a clear write takes effect, and that a set wins over a clear in the same cycle. The timeout count over TIMEOUT_BITS bit periods and its restart on arrival or read can only be shown by the bench scenarios. So can the claim that clear writes leave the level flags untouched, and the one-cycle delay from a mask write to `irq`.

// File: rtl/serial_irq_pkg.sv
package serial_irq_pkg;
  localparam int STAT_W = 7;
  localparam int B_OVR   = 0;
  localparam int B_TMO   = 1;
  localparam int B_RXHI  = 2;
  localparam int B_TXLO  = 3;
  localparam int B_DRX   = 4;
  localparam int B_DTX   = 5;
  localparam int B_TXDRN = 6;
  localparam logic [STAT_W-1:0] STICKY_BITS = 7'b0110011;

  typedef enum logic [1:0] {
    A_RAW    = 2'd0,
    A_MASK   = 2'd1,
    A_MASKED = 2'd2,
    A_CLEAR  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rx_timeout_timer.sv
module rx_timeout_timer #(
  parameter int LVL_W = 4,
  parameter int TIMEOUT_BITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_word_arrive,
  input  logic             rx_word_read,
  input  logic             bit_tick,
  output logic             fire
);
  localparam int CNT_W = $clog2(TIMEOUT_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_BITS - 1);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(TIMEOUT_BITS);

  logic [CNT_W-1:0] cnt_q;
  logic restart;
  assign restart = (rx_level == '0) || rx_word_arrive || rx_word_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (bit_tick && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign fire = !restart && bit_tick && (cnt_q == LAST);
endmodule

// File: rtl/level_flags.sv
module level_flags #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             tx_shift_busy,
  output logic             rx_high,
  output logic             tx_low,
  output logic             tx_drained
);
  localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);
  assign rx_high    = rx_level >= HALF;
  assign tx_low     = tx_level <= HALF;
  assign tx_drained = (tx_level == '0) && !tx_shift_busy;
endmodule

// File: rtl/sticky_event_bank.sv
module sticky_event_bank #(
  parameter int W = 7,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] state
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_keep
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else if (set_vec[i]) q <= 1'b1;
        else if (clr_vec[i]) q <= 1'b0;
      end
      assign state[i] = q;
    end else begin : g_none
      assign state[i] = 1'b0;
    end
  end
endmodule

// File: rtl/serial_irq_unit.sv
module serial_irq_unit
  import serial_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TIMEOUT_BITS = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [STAT_W-1:0] bus_wdata,
  output logic [STAT_W-1:0] bus_rdata,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic              tx_shift_busy,
  input  logic              rx_word_arrive,
  input  logic              rx_word_read,
  input  logic              bit_tick,
  input  logic              dma_rx_done,
  input  logic              dma_tx_done,
  output logic              irq
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic tmo_fire, rx_high, tx_low, tx_drained, ovr_evt;
  logic [STAT_W-1:0] set_vec, clr_vec, sticky, level_vec, raw_stat, mask_q;
  logic wr_en;

  rx_timeout_timer #(.LVL_W(LVL_W), .TIMEOUT_BITS(TIMEOUT_BITS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level),
    .rx_word_arrive(rx_word_arrive), .rx_word_read(rx_word_read),
    .bit_tick(bit_tick), .fire(tmo_fire)
  );

  level_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_lvl (
    .rx_level(rx_level), .tx_level(tx_level), .tx_shift_busy(tx_shift_busy),
    .rx_high(rx_high), .tx_low(tx_low), .tx_drained(tx_drained)
  );

  assign ovr_evt = rx_word_arrive && (rx_level == FULL);

  always_comb begin
    set_vec = '0;
    set_vec[B_OVR] = ovr_evt;
    set_vec[B_TMO] = tmo_fire;
    set_vec[B_DRX] = dma_rx_done;
    set_vec[B_DTX] = dma_tx_done;
    level_vec = '0;
    level_vec[B_RXHI]  = rx_high;
    level_vec[B_TXLO]  = tx_low;
    level_vec[B_TXDRN] = tx_drained;
  end

  assign wr_en   = bus_sel && bus_wr;
  assign clr_vec = (wr_en && bus_addr == A_CLEAR) ? (bus_wdata & STICKY_BITS) : '0;

  sticky_event_bank #(.W(STAT_W), .KEEP(STICKY_BITS)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .state(sticky)
  );

  assign raw_stat = sticky | level_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_en && bus_addr == A_MASK) mask_q <= bus_wdata;
      irq <= |(raw_stat & mask_q);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_RAW:    bus_rdata = raw_stat;
        A_MASK:   bus_rdata = mask_q;
        A_MASKED: bus_rdata = raw_stat & mask_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/serial_irq_unit_chk.sv
module serial_irq_unit_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [6:0]       bus_wdata,
  input logic [6:0]       bus_rdata,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_word_arrive,
  input logic             dma_rx_done,
  input logic             dma_tx_done,
  input logic [6:0]       raw_stat,
  input logic [6:0]       mask_q,
  input logic             irq
);
  AST_RXHI_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 2'd0) |-> bus_rdata[2] == (rx_level >= LVL_W'(DEPTH/2))); // R2
  AST_OVR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_word_arrive && rx_level == LVL_W'(DEPTH)) |=> raw_stat[0]); // R4
  AST_DMA_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rx_done && dma_tx_done) |=> (raw_stat[4] && raw_stat[5])); // R6
  AST_W1C_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd3 && bus_wdata[0] &&
     !(rx_word_arrive && rx_level == LVL_W'(DEPTH))) |=> !raw_stat[0]); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd3 && bus_wdata[4] && dma_rx_done) |=> raw_stat[4]); // R8
  AST_MASKED_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 2'd2) |-> (bus_rdata & ~mask_q) == 7'd0); // R9
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(raw_stat & mask_q))); // R10
  AST_CLR_READ0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 2'd3) |-> bus_rdata == 7'd0); // R11
endmodule

bind serial_irq_unit serial_irq_unit_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_level(rx_level),
  .rx_word_arrive(rx_word_arrive), .dma_rx_done(dma_rx_done), .dma_tx_done(dma_tx_done),
  .raw_stat(raw_stat), .mask_q(mask_q), .irq(irq)
);

// File: tb/serial_irq_unit_tb.sv
module serial_irq_unit_tb;
  localparam int DEPTH = 8;
  localparam int TMO = 32;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [6:0] bus_wdata = 0;
  logic [6:0] bus_rdata;
  logic [LVL_W-1:0] rx_level = 0, tx_level = 0;
  logic tx_shift_busy = 0, rx_word_arrive = 0, rx_word_read = 0, bit_tick = 0;
  logic dma_rx_done = 0, dma_tx_done = 0;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_irq_unit #(.DEPTH(DEPTH), .TIMEOUT_BITS(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_level(rx_level), .tx_level(tx_level),
    .tx_shift_busy(tx_shift_busy), .rx_word_arrive(rx_word_arrive),
    .rx_word_read(rx_word_read), .bit_tick(bit_tick), .dma_rx_done(dma_rx_done),
    .dma_tx_done(dma_tx_done), .irq(irq)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [6:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [6:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; @(negedge clk); bit_tick = 0;
    end
  endtask

  task automatic t_reset();
    logic [6:0] d;
    rd(2'd0, d); check("R1 raw after reset", d, 7'h48);
    rd(2'd1, d); check("R1 mask after reset", d, 0);
    check("R1 irq after reset", irq, 0);
  endtask

  task automatic t_levels();
    logic [6:0] d;
    rx_level = 3; tx_level = 4; #1;
    rd(2'd0, d); check("R2 rx below half", d[2], 0);
    check("R3 tx at half", d[3], 1);
    check("R3 tx not drained", d[6], 0);
    rx_level = 4; tx_level = 5; #1;
    rd(2'd0, d); check("R2 rx at half", d[2], 1);
    check("R3 tx above half", d[3], 0);
    tx_level = 0; tx_shift_busy = 1; #1;
    rd(2'd0, d); check("R3 shifter busy", d[6], 0);
    tx_shift_busy = 0; #1;
    rd(2'd0, d); check("R3 drained", d[6], 1);
    rx_level = 0;
    @(negedge clk);
  endtask

  task automatic t_overrun();
    logic [6:0] d;
    rx_level = 7; rx_word_arrive = 1; @(negedge clk); rx_word_arrive = 0;
    rd(2'd0, d); check("R4 arrive not full", d[0], 0);
    rx_level = 8; rx_word_arrive = 1; @(negedge clk); rx_word_arrive = 0;
    rd(2'd0, d); check("R4 overrun latched", d[0], 1);
    wr(2'd3, 7'h4C);
    rd(2'd0, d); check("R7 level bits and zeros ignored", d, 7'h4D);
    wr(2'd3, 7'h01);
    rd(2'd0, d); check("R7 overrun cleared", d[0], 0);
    check("R7 rx flag kept", d[2], 1);
    rx_level = 0; @(negedge clk);
  endtask

  task automatic t_timeout();
    logic [6:0] d;
    rx_level = 2; @(negedge clk);
    ticks(TMO - 1);
    rd(2'd0, d); check("R5 one tick short", d[1], 0);
    ticks(1);
    rd(2'd0, d); check("R5 timeout latched", d[1], 1);
    wr(2'd3, 7'h02);
    rd(2'd0, d); check("R5 cleared no refire", d[1], 0);
    rx_word_read = 1; @(negedge clk); rx_word_read = 0;
    ticks(20);
    rx_word_arrive = 1; @(negedge clk); rx_word_arrive = 0;
    ticks(TMO - 1);
    rd(2'd0, d); check("R5 restart on arrival", d[1], 0);
    ticks(1);
    rd(2'd0, d); check("R5 timeout after restart", d[1], 1);
    wr(2'd3, 7'h02);
    rx_level = 0; @(negedge clk);
  endtask

  task automatic t_dma();
    logic [6:0] d;
    dma_rx_done = 1; @(negedge clk); dma_rx_done = 0;
    ticks(3);
    rd(2'd0, d); check("R6 rx dma sticky", d[5:4], 2'b01);
    dma_tx_done = 1; @(negedge clk); dma_tx_done = 0;
    rd(2'd0, d); check("R6 tx dma sticky", d[5:4], 2'b11);
    bus_sel = 1; bus_wr = 1; bus_addr = 2'd3; bus_wdata = 7'h30; dma_rx_done = 1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; dma_rx_done = 0;
    rd(2'd0, d); check("R8 set wins, other cleared", d[5:4], 2'b01);
    wr(2'd3, 7'h10);
    rd(2'd0, d); check("R7 dma rx cleared", d[4], 0);
  endtask

  task automatic t_mask_irq();
    logic [6:0] d;
    tx_level = 0;
    rd(2'd3, d); check("R11 clear reads zero", d, 0);
    wr(2'd1, 7'h40);
    check("R10 irq one cycle late", irq, 0);
    rd(2'd1, d); check("R9 mask readback", d, 7'h40);
    rd(2'd2, d); check("R9 masked view", d, 7'h40);
    @(negedge clk);
    check("R10 irq asserted", irq, 1);
    tx_level = 5; @(negedge clk);
    check("R10 irq drops with source", irq, 0);
    wr(2'd1, 7'h00);
    tx_level = 0; @(negedge clk); @(negedge clk);
    check("R9 masked source no irq", irq, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_levels();
    t_overrun();
    t_timeout();
    t_dma();
    t_mask_irq();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule